// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block controls the on-demand self-calibration of a pipelined analog-to-digital converter. A start request arrives on a pin that has no timing relation to the converter clock. The block passes it through a two-stage synchronizer and checks that it stays high long enough. It then holds the converter in calibration for a fixed number of clocks. The mismatch measurement and the coefficient arithmetic sit outside the block, and a simple interval counter stands in for their duration.

While calibration runs, the block drives its status output low and raises an enable for the calibration datapath. It also blocks the normal conversion path: the conversion enable drops, and any data-valid strobe from the conversion pipeline is held off. Once the interval ends, the status returns high and conversion resumes. A start request that arrives during calibration has no effect. A request held high for a long time starts only one calibration.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset, `cal_done` is 1, `cal_active` is 0 and `conv_en` is 1, and no calibration runs until a qualified start request arrives.
- R2: `cal_req_async` passes through a two-flop synchronizer. A request counts as valid only when the synchronized level is high on at least MIN_WIDTH (default 4) consecutive clock edges.
- R3: A request that is high for fewer than MIN_WIDTH sampling edges (for example 1 or 3) starts no calibration, and `cal_done` stays 1.
- R4: For a valid request, `cal_done` falls on the sixth rising edge, counting as the first the edge at which `cal_req_async` is first sampled high. It is still 1 after the fifth edge.
- R5: `cal_done` stays low for exactly CAL_LEN clock cycles (default 17400) and then returns to 1.
- R6: Any start activity while calibration runs has no effect. The end time is unchanged, and no second calibration follows. A request held high across the whole interval starts only one calibration.
- R7: While calibrating, `cal_active` is 1 and `conv_en` is 0. Otherwise `cal_active` is 0 and `conv_en` is 1.
- R8: `vld_out` equals `vld_in` while `conv_en` is 1, and is 0 while calibration runs.
- R9: After a calibration completes and the request has gone low, a new valid request starts another calibration with the same timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; must run continuously |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req_async | input | 1 | Asynchronous calibration start request, active high |
| vld_in | input | 1 | Data-valid strobe from the conversion pipeline |
| cal_done | output | 1 | 1 = normal conversion, 0 = calibration in progress |
| cal_active | output | 1 | Enable for the calibration datapath |
| conv_en | output | 1 | Enable for the normal conversion path |
| vld_out | output | 1 | Data-valid strobe, gated off during calibration |

## Verification
On every cycle, the assertions check these properties:
- a qualified request that arrives while idle starts calibration on the next edge;
- the interval counter steps by exactly one while busy, so a late request cannot restart it;
- busy clears right after the last count;
- the qualifier never fires on two cycles in a row;
- a falling status always follows a qualifier pulse;
- the data-valid strobe never passes while conversion is disabled.

Only the bench scenarios can show the behaviour measured from the pins. This covers the exact edge on which the status falls after the asynchronous input rises, the rejection of pulses that are too short, the full 17400-cycle length, and the absence of a second calibration after a long or overlapping request.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  // Saturating increment used by the pulse-width qualifier.
  function automatic int unsigned run_next(input int unsigned cur, input int unsigned limit, input logic level);
    if (!level)
      return 0;
    else if (cur >= limit)
      return limit;
    else
      return cur + 1;
  endfunction

  // True on the final cycle of the calibration interval.
  function automatic logic is_final(input int unsigned cnt, input int unsigned len);
    return (cnt == len - 1);
  endfunction

endpackage

// File: rtl/cal_req_sync.sv
module cal_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chain_q <= '0;
    else
      chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cal_req_qual.sv
module cal_req_qual
  import cal_seq_pkg::*;
#(
  parameter int MIN_WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fire_o
);
  localparam int RW = $clog2(MIN_WIDTH + 1);
  localparam logic [RW-1:0] LIMIT = RW'(MIN_WIDTH);
  localparam logic [RW-1:0] ARM   = RW'(MIN_WIDTH - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else
      run_q <= RW'(run_next(int'(run_q), MIN_WIDTH, level_i));
  end

  // Fire once, on the MIN_WIDTH-th consecutive high sample.
  assign fire_o = level_i && (run_q == ARM);

  AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o); // R6

  AST_SAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LIMIT); // R2
endmodule

// File: rtl/cal_interval_timer.sv
module cal_interval_timer
  import cal_seq_pkg::*;
#(
  parameter int CAL_LEN = 17400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CAL_LEN);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          last_w;
  logic          take_w;

  assign last_w = is_final(int'(cnt_q), CAL_LEN);
  assign take_w = start_i && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take_w) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last_w) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign busy_o = busy_q;

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> busy_q); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_w) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1))); // R6

  AST_END_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last_w) |=> !busy_q); // R5
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 4,
  parameter int CAL_LEN     = 17400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req_async,
  input  logic vld_in,
  output logic cal_done,
  output logic cal_active,
  output logic conv_en,
  output logic vld_out
);
  logic req_sync_w;
  logic req_fire_w;
  logic busy_w;

  cal_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(cal_req_async),
    .sync_o (req_sync_w)
  );

  cal_req_qual #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(req_sync_w),
    .fire_o (req_fire_w)
  );

  cal_interval_timer #(.CAL_LEN(CAL_LEN)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(req_fire_w),
    .busy_o (busy_w)
  );

  assign cal_active = busy_w;
  assign cal_done   = !busy_w;
  assign conv_en    = !busy_w;
  assign vld_out    = vld_in && conv_en;

  AST_FALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_done) |-> $past(req_fire_w)); // R2

  AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cal_active |-> !vld_out); // R8

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_active && conv_en)); // R7
endmodule

// File: tb/cal_seq_ctrl_tb.sv
module cal_seq_ctrl_tb;
  localparam int CAL_LEN = 17400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req_async = 1'b0;
  logic vld_in = 1'b0;
  logic cal_done, cal_active, conv_en, vld_out;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cal_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cal_req_async(cal_req_async), .vld_in(vld_in),
    .cal_done(cal_done), .cal_active(cal_active), .conv_en(conv_en), .vld_out(vld_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Short pulse: sampled high on w edges, then must be ignored.
  task automatic t_short(input int w);
    int lows = 0;
    @(negedge clk) cal_req_async = 1'b1;
    repeat (w) @(negedge clk);
    cal_req_async = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (cal_done !== 1'b1) lows++;
    end
    chk("R3 short pulse ignored (low cycles)", lows, 0);
  endtask

  // Full calibration; width = edges the request is sampled high,
  // ovl = edge index at which an extra 8-edge request is sent (0 = none).
  task automatic t_cal(input int width, input int ovl, input string tag);
    int tail_lows = 0;
    vld_in = 1'b1;
    @(negedge clk);
    chk({tag, " R8 strobe passes while idle"}, int'(vld_out), 1);
    cal_req_async = 1'b1;
    for (int k = 1; k <= 6 + CAL_LEN; k++) begin
      @(negedge clk);
      if (k == width) cal_req_async = 1'b0;
      if (ovl != 0 && k == ovl) cal_req_async = 1'b1;
      if (ovl != 0 && k == ovl + 8) cal_req_async = 1'b0;
      if (k == 5) chk({tag, " R4 done still high after edge 5"}, int'(cal_done), 1);
      if (k == 6) chk({tag, " R4 done low at edge 6"}, int'(cal_done), 0);
      if (k == 100) begin
        chk({tag, " R7 cal_active during cal"}, int'(cal_active), 1);
        chk({tag, " R7 conv_en during cal"}, int'(conv_en), 0);
        chk({tag, " R8 strobe suppressed"}, int'(vld_out), 0);
      end
      if (k == 5 + CAL_LEN) chk({tag, " R5 done low on last cycle"}, int'(cal_done), 0);
      if (k == 6 + CAL_LEN) chk({tag, " R5 done high after CAL_LEN"}, int'(cal_done), 1);
    end
    cal_req_async = 1'b0;
    chk({tag, " R7 conv_en restored"}, int'(conv_en), 1);
    chk({tag, " R8 strobe passes again"}, int'(vld_out), 1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (cal_done !== 1'b1) tail_lows++;
    end
    chk({tag, " R6 no second calibration"}, tail_lows, 0);
    vld_in = 1'b0;
    @(negedge clk);
    chk({tag, " R8 strobe low follows input"}, int'(vld_out), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 cal_done in reset", int'(cal_done), 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 cal_done after reset", int'(cal_done), 1);
    chk("R1 cal_active after reset", int'(cal_active), 0);
    chk("R1 conv_en after reset", int'(conv_en), 1);
  endtask

  initial begin
    t_reset();
    t_short(1);
    t_short(3);
    t_cal(4, 0, "R2 min-width");
    t_cal(9000, 0, "R6 long-held");
    t_cal(4, 5000, "R6 overlap");
    t_cal(5, 0, "R9 restart");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule